// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a half-duplex serial slave that lets an external master read and write a small bank of 8-bit configuration registers. The master selects it with an active-low select line and clocks bits in with a serial clock. In the default three-wire mode, the single data line carries the instruction, the write data and the read data. Register 0 can switch the block to four-wire mode, where read data leaves on a separate output pin. Register 0 can also switch both the instruction and the data from most-significant-bit-first to least-significant-bit-first.

Every transaction starts with a 16-bit instruction word. Bit 15 is the direction (1 = read), bits 14:13 are the byte count, and bits 12:0 are the starting address. Data bytes follow the instruction. The address moves by one after each byte: up in MSB-first order and down in LSB-first order.

Short transfers may be paused at any byte boundary by releasing the select line. Streaming transfers may be paused only inside the instruction or just before the first data byte. The serial inputs are assumed to be synchronous to `clk`, which must run at least several times faster than the serial clock.

Top module: `spi_cfg_slave`

## Requirements
- R1: After reset, every register reads 0x00 and both output enables are low.
- R2: In MSB-first order the instruction arrives bit 15 first. Bit 15 = 1 selects a read, bits 14:13 give the byte count, and bits 12:0 give the start address. Input bits are sampled on the rising serial clock edge.
- R3: The byte count code maps 00 to 1 byte, 01 to 2, 10 to 3, and 11 to streaming until select rises. Serial clocks after a short transfer has finished are ignored.
- R4: Registers exist at addresses 0x00 to 0x0F. A write to any other address changes no register, and a read of any other address returns 0x00.
- R5: Register 0 bit 6 = 1 selects LSB-first order for both the instruction (bit 0 first) and the data (bit 0 first). A change takes effect from the next transaction.
- R6: Register 0 bit 7 = 1 selects four-wire mode. Read data is then driven on `sdo_o` with `sdo_oe` high, and `sdio_oe` stays low. A change takes effect from the next transaction.
- R7: After each data byte the address increments in MSB-first order and decrements in LSB-first order.
- R8: Read data bits are launched on the falling serial clock edge. An output enable is high only during the data phase of a read while select is low.
- R9: In a 1 to 3 byte transfer, select may go high at any byte boundary, and the transfer resumes when select falls again. A streaming transfer may be paused at the instruction byte boundary or before its first data byte.
- R10: Select rising in the middle of a byte, or after at least one data byte of a streaming transfer, returns the block to idle. The next transaction then starts with a fresh instruction.
- R11: Bits 5:0 of register 0 are reserved and always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the serial inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low select from the master |
| sclk | input | 1 | Serial clock from the master |
| sdio_i | input | 1 | Input side of the bidirectional data line |
| sdio_o | output | 1 | Output side of the bidirectional data line |
| sdio_oe | output | 1 | Drive enable for the bidirectional data line |
| sdo_o | output | 1 | Dedicated read data output for four-wire mode |
| sdo_oe | output | 1 | Drive enable for the dedicated output |

## Verification
The hardest state to reach is a select release that is legal in one transfer and fatal in another: the same byte-boundary release must resume a short transfer but kill a streaming one. The stimulus therefore runs the same pause pattern in both cases. After a streaming abort it sends a read instruction at once. A block that wrongly kept the burst alive would take those 16 bits as write data and corrupt two registers, which the following reads expose. A release after half a data byte is driven separately, and the target register is read back to confirm the byte was dropped.

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave #(
  parameter int NREGS = 16,
  parameter int AW    = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdio_i,
  output logic sdio_o,
  output logic sdio_oe,
  output logic sdo_o,
  output logic sdo_oe
);
  localparam int IW  = AW + 3;
  localparam int ICW = $clog2(IW);
  localparam int RIW = $clog2(NREGS);

  typedef enum logic [1:0] {P_INS, P_DAT, P_END} ph_t;

  ph_t            ph;
  logic           sclk_q;
  logic [7:0]     regs [NREGS];
  logic [IW-1:0]  ins;
  logic [ICW-1:0] icnt;
  logic [2:0]     dcnt;
  logic [7:0]     wsh;
  logic           rw, lsb, four, obit;
  logic [1:0]     len, bdone;
  logic [AW-1:0]  addr;
  logic [7:0]     rdata;

  wire rise = sclk & ~sclk_q & ~cs_n;
  wire fall = ~sclk & sclk_q & ~cs_n;
  wire idle = (ph == P_INS) && (icnt == '0);
  wire hit  = addr < AW'(NREGS);

  wire [IW-1:0] ins_nx = lsb ? {sdio_i, ins[IW-1:1]} : {ins[IW-2:0], sdio_i};
  wire [7:0]    wb_nx  = lsb ? {sdio_i, wsh[7:1]}    : {wsh[6:0], sdio_i};
  wire [2:0]    oidx   = lsb ? dcnt : 3'd7 - dcnt;

  wire abort_cs = cs_n && (
      (ph == P_INS && icnt != '0 && icnt != ICW'(8)) ||
      (ph == P_DAT && (dcnt != '0 || (len == 2'd3 && bdone != '0))) ||
      (ph == P_END));

  always_comb rdata = hit ? regs[addr[RIW-1:0]] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= P_INS; sclk_q <= 1'b0; ins <= '0; icnt <= '0; dcnt <= '0;
      wsh <= '0; rw <= 1'b0; lsb <= 1'b0; four <= 1'b0; obit <= 1'b0;
      len <= '0; bdone <= '0; addr <= '0;
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else begin
      sclk_q <= sclk;
      if (idle) begin
        lsb  <= regs[0][6];
        four <= regs[0][7];
      end
      if (abort_cs) begin
        ph <= P_INS; icnt <= '0; dcnt <= '0; bdone <= '0;
      end else if (rise) begin
        case (ph)
          P_INS: begin
            ins <= ins_nx;
            if (icnt == ICW'(IW-1)) begin
              ph    <= P_DAT;
              icnt  <= '0;
              rw    <= ins_nx[IW-1];
              len   <= ins_nx[IW-2:IW-3];
              addr  <= ins_nx[AW-1:0];
              dcnt  <= '0;
              bdone <= '0;
            end else begin
              icnt <= icnt + 1'b1;
            end
          end
          P_DAT: begin
            wsh  <= wb_nx;
            dcnt <= dcnt + 1'b1;
            if (dcnt == 3'd7) begin
              if (!rw && hit)
                regs[addr[RIW-1:0]] <= (addr == '0) ? (wb_nx & 8'hC0) : wb_nx;
              addr <= lsb ? addr - AW'(1) : addr + AW'(1);
              if (bdone != 2'd3) bdone <= bdone + 1'b1;
              if (len != 2'd3 && bdone == len) ph <= P_END;
            end
          end
          default: ;
        endcase
      end
      if (fall && ph == P_DAT) obit <= rdata[oidx];
    end
  end

  wire drv = (ph == P_DAT) && rw && !cs_n;
  assign sdio_oe = drv & ~four;
  assign sdo_oe  = drv & four;
  assign sdio_o  = obit;
  assign sdo_o   = obit;

  // R9
  pause_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && ph == P_DAT && len != 2'd3 && dcnt == 3'd0) |=> (ph == P_DAT && $stable(addr)));
  // R10
  mid_byte_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && ph == P_DAT && dcnt != 3'd0) |=> (ph == P_INS && icnt == '0));
  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && ph == P_DAT && dcnt == 3'd7 && !cs_n) |=>
      (addr == ($past(lsb) ? $past(addr) - AW'(1) : $past(addr) + AW'(1))));
  // R8
  launch_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(obit));
  // R6
  one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdio_oe && sdo_oe));
  // R11
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regs[0][5:0] == 6'd0);
endmodule

// File: tb/sim_spi_cfg_slave.sv
module sim_spi_cfg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdio_i = 1'b0;
  logic sdio_o, sdio_oe, sdo_o, sdo_oe;
  int checks = 0, errors = 0;
  logic [7:0] mem [16];
  bit m_lsb = 0, m_four = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cfg_slave u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_i(sdio_i),
                    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cs(bit v);
    wclk(HALF);
    cs_n = v;
    wclk(HALF);
    if (v) begin
      chk("R8 sdio_oe idle", int'(sdio_oe), 0);
      chk("R8 sdo_oe idle", int'(sdo_oe), 0);
    end
  endtask

  task automatic bit_io(bit b, bit rd, output bit r);
    sdio_i = b;
    wclk(HALF);
    sclk = 1'b1;
    r = m_four ? sdo_o : sdio_o;
    if (rd) begin
      if (sdio_oe !== !m_four || sdo_oe !== m_four) begin
        chk("R6/R8 enables in read", int'({sdio_oe, sdo_oe}), int'({!m_four, m_four}));
      end
    end else if (sdio_oe || sdo_oe) begin
      chk("R8 enable outside read", int'({sdio_oe, sdo_oe}), 0);
    end
    wclk(HALF);
    sclk = 1'b0;
    wclk(HALF);
  endtask

  task automatic send_part(logic [15:0] w, int k0, int k1);
    bit r;
    for (int k = k0; k < k1; k++) bit_io(m_lsb ? w[k] : w[15-k], 1'b0, r);
  endtask

  task automatic xbyte(logic [7:0] wb, bit rd, output logic [7:0] rb);
    bit r;
    for (int i = 0; i < 8; i++) begin
      int idx = m_lsb ? i : 7 - i;
      bit_io(wb[idx], rd, r);
      rb[idx] = r;
    end
  endtask

  function automatic logic [15:0] iword(bit rd, int n, int a);
    logic [1:0] l = (n >= 4) ? 2'd3 : 2'(n - 1);
    return {rd, l, 13'(a)};
  endfunction

  function automatic int nexta(int a);
    return m_lsb ? ((a - 1) & 16'h1FFF) : ((a + 1) & 16'h1FFF);
  endfunction

  function automatic logic [7:0] model_rd(int a);
    return (a < 16) ? mem[a] : 8'h00;
  endfunction

  task automatic model_wr(int a, logic [7:0] v);
    if (a < 16) mem[a] = (a == 0) ? (v & 8'hC0) : v;
  endtask

  task automatic do_write(int a, logic [7:0] q[$]);
    logic [7:0] rb;
    set_cs(0);
    send_part(iword(0, q.size(), a), 0, 16);
    foreach (q[i]) begin
      xbyte(q[i], 0, rb);
      model_wr(a, q[i]);
      a = nexta(a);
    end
    set_cs(1);
    m_lsb = mem[0][6];
    m_four = mem[0][7];
  endtask

  task automatic do_read(string req, int a, int n, bit stream);
    logic [7:0] rb;
    set_cs(0);
    send_part(iword(1, stream ? 4 : n, a), 0, 16);
    for (int i = 0; i < n; i++) begin
      xbyte(8'h00, 1, rb);
      chk(req, int'(rb), int'(model_rd(a)));
      a = nexta(a);
    end
    set_cs(1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rb;
    logic [15:0] w;
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    wclk(5);
    rst_n = 1'b1;
    wclk(2);
    // R1 reset state
    chk("R1 sdio_oe", int'(sdio_oe), 0);
    chk("R1 sdo_oe", int'(sdo_oe), 0);
    do_read("R1 R3 stream read after reset", 0, 16, 1);

    // R2 single byte write and read
    do_write(2, '{8'hA5});
    do_read("R2 R4 single read", 2, 1, 0);

    // R3 R7 three-byte burst, increment
    do_write(4, '{8'h11, 8'h22, 8'h33});
    do_read("R3 R7 three-byte read", 4, 3, 0);

    // R4 undefined addresses
    do_write(16'h20, '{8'hFF});
    do_write(16'h1005, '{8'hFF});
    do_write(16'h0F, '{8'h77, 8'h88, 8'h99, 8'h44});
    do_read("R4 bank intact", 0, 16, 1);
    do_read("R4 undefined reads zero", 16'h10, 1, 0);

    // R11 reserved bits
    do_write(0, '{8'h3F});
    do_read("R11 reg0 reserved", 0, 1, 0);

    // R9 streaming pause before first data byte, then R10 abort after a data byte
    w = iword(0, 4, 1);
    set_cs(0);
    send_part(w, 0, 8);
    set_cs(1);
    set_cs(0);
    send_part(w, 8, 16);
    set_cs(1);
    set_cs(0);
    xbyte(8'h5A, 0, rb); model_wr(1, 8'h5A);
    set_cs(1);
    set_cs(0);
    send_part(iword(1, 1, 2), 0, 16);
    xbyte(8'h00, 1, rb);
    chk("R10 fresh instruction after stream abort", int'(rb), int'(model_rd(2)));
    set_cs(1);
    do_read("R10 R9 stream regs", 1, 3, 0);

    // R10 mid-byte release drops the byte
    set_cs(0);
    send_part(iword(0, 1, 3), 0, 16);
    for (int i = 0; i < 4; i++) begin
      bit r;
      bit_io(1'b1, 0, r);
    end
    set_cs(1);
    do_read("R10 partial byte ignored", 3, 1, 0);

    // R9 short transfer with pauses everywhere
    w = iword(0, 3, 8);
    set_cs(0); send_part(w, 0, 8); set_cs(1);
    set_cs(0); send_part(w, 8, 16); set_cs(1);
    set_cs(0); xbyte(8'hAA, 0, rb); set_cs(1);
    set_cs(0); xbyte(8'hBB, 0, rb); set_cs(1);
    set_cs(0); xbyte(8'hCC, 0, rb);
    xbyte(8'hEE, 0, rb);
    set_cs(1);
    model_wr(8, 8'hAA); model_wr(9, 8'hBB); model_wr(10, 8'hCC);
    w = iword(1, 3, 8);
    set_cs(0); send_part(w, 0, 16);
    xbyte(0, 1, rb); chk("R9 paused read byte0", int'(rb), int'(model_rd(8)));
    set_cs(1); set_cs(0);
    xbyte(0, 1, rb); chk("R9 paused read byte1", int'(rb), int'(model_rd(9)));
    xbyte(0, 1, rb); chk("R9 paused read byte2", int'(rb), int'(model_rd(10)));
    set_cs(1);
    do_read("R3 R9 trailing clocks ignored", 11, 1, 0);

    // R5 R7 LSB-first with decrement
    do_write(0, '{8'h40});
    do_write(9, '{8'h3C, 8'h5D});
    do_read("R5 R7 lsb read", 9, 2, 0);
    do_read("R5 R7 lsb stream", 3, 5, 1);

    // R6 four-wire MSB-first
    do_write(0, '{8'h80});
    do_read("R6 four-wire read", 4, 3, 0);

    // R5 R6 four-wire LSB-first
    do_write(0, '{8'hC0});
    do_read("R5 R6 four-wire lsb read", 5, 2, 0);
    do_read("R11 reg0 value", 0, 1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule